// File: doc/BRIEF.md
# Reference Clock Loss Monitor with Fallback Output

This block watches a slow external reference clock (nominally 32 kHz, from a crystal amplifier or from a square wave fed straight to a pin) using a faster internal monitor clock (nominally 5 MHz). A gap counter, restarted by every rising reference edge, declares the reference lost when no edge arrives inside a timeout window. Loss raises a sticky fault flag and an OR-summary flag. Software has a strobe for each flag and a bit that asks for the external clock on the auxiliary output.

The auxiliary clock output comes from the external reference only when the fault flag is clear and software asks for it. At all other times it comes from the monitor clock divided by a fixed power of two. Every handover between the two sources is break-before-make, so the output never shows a shortened high pulse. A fault clear takes effect only after a long run of consecutive good reference cycles since the last loss. This stops a flickering source from being re-admitted too early.

Top module: `osc_guard`

## Requirements
- R1: After reset, `fault_o` = 1 and `sum_o` = 1, and `aux_clk_o` runs from the fallback clock.
- R2: The fallback clock is `clk` divided by `FB_DIV`, high for `FB_DIV/2` cycles. It drives `aux_clk_o` whenever the fault flag is set.
- R3: When no rising edge of the selected reference is seen for `TIMEOUT_CYC` monitor cycles, `fault_o` becomes 1. This includes a reference whose period is stretched beyond the timeout.
- R4: Reference periods that stay below the timeout never raise a fault, however much they vary. Once set, `fault_o` stays 1 after the reference returns, until a clear is accepted.
- R5: A `clr_fault_i` strobe clears `fault_o` only if at least `GOOD_REF` rising reference edges have been seen since the last loss. An earlier strobe leaves the flag at 1.
- R6: `sum_o` is forced to 1 while `fault_o` is 1. `clr_sum_i` clears it only in a cycle where `fault_o` is already 0, so a summary clear given in the same cycle as an accepted fault clear is ignored.
- R7: With `bypass_i` = 1, the reference is taken from `ref_pin_i` and `amp_on_o` = 0. With `bypass_i` = 0, it is taken from `ref_xtal_i` and `amp_on_o` = 1.
- R8: `aux_clk_o` follows the external reference only while `fault_o` = 0 and `sel_ext_i` = 1. Otherwise it follows the fallback clock.
- R9: No high pulse on `aux_clk_o` is shorter than the shorter high phase of the two sources, including across source changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal monitor clock, also the base of the fallback clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_xtal_i | input | 1 | Reference from the crystal amplifier (asynchronous) |
| ref_pin_i | input | 1 | Reference square wave fed straight to the pin (asynchronous) |
| bypass_i | input | 1 | 1 = use pin input and power the amplifier down |
| sel_ext_i | input | 1 | 1 = request the external reference on the output |
| clr_fault_i | input | 1 | One-cycle strobe to clear the fault flag |
| clr_sum_i | input | 1 | One-cycle strobe to clear the summary flag |
| fault_o | output | 1 | Sticky reference-loss flag |
| sum_o | output | 1 | Summary oscillator-fault flag |
| aux_clk_o | output | 1 | Auxiliary clock output |
| amp_on_o | output | 1 | Amplifier enable, low in bypass mode |

## Verification
The fault clear and the summary clear can land in the same cycle. The bench makes the first accepted fault clear with both strobes raised together, then expects `fault_o` = 0 with `sum_o` still 1, and a later lone summary strobe to bring `sum_o` to 0. The edge count that gates the clear is probed with a clear one edge short of `GOOD_REF` and one exactly at it. Random restarts then place the clear at edge counts drawn from both sides of the threshold. A monitor measures every high run on the output across all the handovers these events cause.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;
  typedef enum logic [1:0] {
    SRC_FB     = 2'd0,
    SRC_TO_EXT = 2'd1,
    SRC_EXT    = 2'd2,
    SRC_TO_FB  = 2'd3
  } src_state_t;
endpackage

// File: rtl/osc_guard_sync.sv
module osc_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/osc_guard_loss.sv
module osc_guard_loss #(
  parameter int TIMEOUT_CYC = 500,
  parameter int GOOD_REF    = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_s,
  output logic starved,
  output logic good_ok
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam int GW = $clog2(GOOD_REF + 1);
  localparam logic [CW-1:0] GAP_MAX  = CW'(TIMEOUT_CYC);
  localparam logic [GW-1:0] GOOD_MAX = GW'(GOOD_REF);

  logic          ref_d;
  logic          rise;
  logic [CW-1:0] gap_cnt;
  logic [GW-1:0] good_cnt;

  always_ff @(posedge clk) begin
    if (rst) ref_d <= 1'b0;
    else     ref_d <= ref_s;
  end

  assign rise = ref_s & ~ref_d;

  // retriggerable one-shot: each rising edge restarts the window
  always_ff @(posedge clk) begin
    if (rst)                gap_cnt <= GAP_MAX;
    else if (rise)          gap_cnt <= '0;
    else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
  end

  assign starved = (gap_cnt == GAP_MAX);

  // consecutive good edges since the last loss, saturating
  always_ff @(posedge clk) begin
    if (rst)                         good_cnt <= '0;
    else if (rise) begin
      if (good_cnt != GOOD_MAX)      good_cnt <= good_cnt + 1'b1;
    end
    else if (starved)                good_cnt <= '0;
  end

  assign good_ok = (good_cnt == GOOD_MAX);
endmodule

// File: rtl/osc_guard_flags.sv
module osc_guard_flags (
  input  logic clk,
  input  logic rst,
  input  logic starved,
  input  logic good_ok,
  input  logic clr_fault,
  input  logic clr_sum,
  output logic fault_q,
  output logic sum_q
);
  always_ff @(posedge clk) begin
    if (rst)                       fault_q <= 1'b1;
    else if (starved)              fault_q <= 1'b1;
    else if (clr_fault && good_ok) fault_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          sum_q <= 1'b1;
    else if (fault_q) sum_q <= 1'b1;
    else if (clr_sum) sum_q <= 1'b0;
  end
endmodule

// File: rtl/osc_guard_div.sv
module osc_guard_div #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  output logic lvl
);
  localparam int DW = $clog2(DIV);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign lvl = cnt[DW-1];
endmodule

// File: rtl/osc_guard_clkmux.sv
module osc_guard_clkmux
  import osc_guard_pkg::*;
#(
  parameter int REQ_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic want_ext,
  input  logic ext_lvl,
  input  logic fb_lvl,
  input  logic ext_dead,
  output logic aux_q
);
  logic [REQ_STAGES-1:0] req_pipe;
  logic                  req;
  src_state_t            st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) req_pipe <= '0;
    else     req_pipe <= {req_pipe[REQ_STAGES-2:0], want_ext};
  end

  assign req = req_pipe[REQ_STAGES-1];

  always_comb begin
    st_nx = st;
    case (st)
      SRC_FB:     if (req && !fb_lvl) st_nx = SRC_TO_EXT;
      SRC_TO_EXT: if (!req)           st_nx = SRC_TO_FB;
                  else if (!ext_lvl)  st_nx = SRC_EXT;
      SRC_EXT:    if (!req && (!ext_lvl || ext_dead)) st_nx = SRC_TO_FB;
      SRC_TO_FB:  if (!fb_lvl)        st_nx = SRC_FB;
      default:                        st_nx = SRC_FB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SRC_FB;
      aux_q <= 1'b0;
    end else begin
      st    <= st_nx;
      aux_q <= ((st == SRC_FB) && fb_lvl) || ((st == SRC_EXT) && ext_lvl);
    end
  end
endmodule

// File: rtl/osc_guard.sv
module osc_guard #(
  parameter int TIMEOUT_CYC = 500,
  parameter int GOOD_REF    = 1024,
  parameter int FB_DIV      = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_xtal_i,
  input  logic ref_pin_i,
  input  logic bypass_i,
  input  logic sel_ext_i,
  input  logic clr_fault_i,
  input  logic clr_sum_i,
  output logic fault_o,
  output logic sum_o,
  output logic aux_clk_o,
  output logic amp_on_o
);
  logic ref_raw;
  logic ref_s;
  logic starved;
  logic good_ok;
  logic fb_lvl;
  logic want_ext;

  assign ref_raw = bypass_i ? ref_pin_i : ref_xtal_i;

  always_ff @(posedge clk) begin
    if (rst) amp_on_o <= 1'b1;
    else     amp_on_o <= ~bypass_i;
  end

  osc_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ref_raw), .q(ref_s)
  );

  osc_guard_loss #(.TIMEOUT_CYC(TIMEOUT_CYC), .GOOD_REF(GOOD_REF)) u_loss (
    .clk(clk), .rst(rst), .ref_s(ref_s), .starved(starved), .good_ok(good_ok)
  );

  osc_guard_flags u_flags (
    .clk(clk), .rst(rst), .starved(starved), .good_ok(good_ok),
    .clr_fault(clr_fault_i), .clr_sum(clr_sum_i),
    .fault_q(fault_o), .sum_q(sum_o)
  );

  osc_guard_div #(.DIV(FB_DIV)) u_div (
    .clk(clk), .rst(rst), .lvl(fb_lvl)
  );

  assign want_ext = ~fault_o & sel_ext_i;

  osc_guard_clkmux #(.REQ_STAGES(SYNC_STAGES)) u_mux (
    .clk(clk), .rst(rst), .want_ext(want_ext), .ext_lvl(ref_s),
    .fb_lvl(fb_lvl), .ext_dead(starved), .aux_q(aux_clk_o)
  );
endmodule

// File: rtl/osc_guard_chk.sv
module osc_guard_chk (
  input logic clk,
  input logic rst,
  input logic fault,
  input logic sum,
  input logic starved,
  input logic good_ok,
  input logic clr_fault,
  input logic clr_sum
);
  a_r3_fault_from_loss: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(starved));

  a_r4_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    fault && !clr_fault |=> fault);

  a_r5_clear_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(fault) |-> $past(good_ok && clr_fault));

  a_r6_sum_follows_fault: assert property (@(posedge clk) disable iff (rst)
    fault |=> sum);

  a_r6_sum_clear_legal: assert property (@(posedge clk) disable iff (rst)
    $fell(sum) |-> $past(clr_sum && !fault));
endmodule

bind osc_guard osc_guard_chk u_chk (
  .clk(clk), .rst(rst), .fault(fault_o), .sum(sum_o),
  .starved(starved), .good_ok(good_ok),
  .clr_fault(clr_fault_i), .clr_sum(clr_sum_i)
);

// File: tb/osc_guard_tb.sv
`timescale 1ns/1ps
module osc_guard_tb;
  localparam int TO   = 60;
  localparam int GOOD = 16;
  localparam int DIV  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_xtal = 1'b0, ref_pin = 1'b0, bypass = 1'b0, sel_ext = 1'b0;
  logic clr_fault = 1'b0, clr_sum = 1'b0;
  logic fault, sum, aux, amp_on;

  int errors = 0, checks = 0;
  int rises = 0, runts = 0, hrun = 0;
  bit run = 0, route_pin = 0, lvl = 0, done = 0;
  int hmin = 10, hmax = 10, ph = 0;

  always #10 clk = ~clk;

  osc_guard #(.TIMEOUT_CYC(TO), .GOOD_REF(GOOD), .FB_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .ref_xtal_i(ref_xtal), .ref_pin_i(ref_pin),
    .bypass_i(bypass), .sel_ext_i(sel_ext), .clr_fault_i(clr_fault),
    .clr_sum_i(clr_sum), .fault_o(fault), .sum_o(sum),
    .aux_clk_o(aux), .amp_on_o(amp_on)
  );

  function automatic int pick_half(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  function automatic int exp_fault_after_clear(input int edges);
    return (edges >= GOOD) ? 0 : 1;
  endfunction

  // reference driver
  initial begin
    forever begin
      @(negedge clk);
      if (!run) begin
        lvl = 0; ph = 0;
      end else if (ph == 0) begin
        lvl = !lvl;
        if (lvl) rises++;
        ph = pick_half(hmin, hmax) - 1;
      end else ph--;
      ref_xtal = route_pin ? 1'b0 : lvl;
      ref_pin  = route_pin ? lvl : 1'b0;
    end
  end

  // high-run monitor for R9
  initial begin
    forever begin
      @(negedge clk);
      if (aux) hrun++;
      else begin
        if (hrun > 0 && hrun < 4 && !rst) runts++;
        hrun = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(input string tag, input int act, input int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_edges(input int w, output int n);
    bit prev;
    n = 0;
    @(negedge clk);
    prev = aux;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (aux && !prev) n++;
      prev = aux;
    end
  endtask

  task automatic do_clear(input bit f, input bit s);
    @(negedge clk);
    clr_fault = f; clr_sum = s;
    @(negedge clk);
    clr_fault = 0; clr_sum = 0;
    @(negedge clk);
  endtask

  task automatic restart_after(input int target, output int base);
    run = 0;
    cycles(TO + 20);
    base = rises;
    run = 1;
    wait (rises == base + target);
    cycles(5);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int n, base, edges;
    void'($urandom(32'd4711));
    cycles(10);
    rst = 0;
    cycles(2);
    chk("R1 fault after reset", fault, 1);
    chk("R1 sum after reset", sum, 1);
    chk("R7 amp on without bypass", amp_on, 1);
    count_edges(640, n);
    chk_near("R1 R2 fallback after reset", n, 640 / DIV);

    // R5 early clear refused, exact-threshold clear accepted; R6 same-cycle strobes
    sel_ext = 1;
    hmin = 10; hmax = 10;
    run = 1;
    wait (rises == GOOD - 1);
    cycles(5);
    do_clear(1, 0);
    chk("R5 clear one edge short", fault, 1);
    wait (rises == GOOD);
    cycles(5);
    do_clear(1, 1);
    chk("R5 clear at threshold", fault, 0);
    chk("R6 sum kept on same-cycle clear", sum, 1);
    do_clear(0, 1);
    chk("R6 sum clear alone", sum, 0);

    cycles(100);
    count_edges(640, n);
    chk_near("R8 external on output", n, 640 / 20);
    sel_ext = 0;
    cycles(100);
    count_edges(640, n);
    chk_near("R8 fallback when deselected", n, 640 / DIV);
    sel_ext = 1;

    // R4 jitter tolerance
    hmin = 6; hmax = 14;
    cycles(3000);
    chk("R4 jitter no fault", fault, 0);

    // R3 loss timing
    run = 0;
    cycles(20);
    chk("R3 no fault before timeout", fault, 0);
    cycles(55);
    chk("R3 fault after timeout", fault, 1);
    chk("R6 sum set by fault", sum, 1);
    run = 1;
    hmin = 10; hmax = 10;
    base = rises;
    wait (rises == base + 40);
    cycles(5);
    chk("R4 fault sticky after return", fault, 1);
    count_edges(640, n);
    chk_near("R2 fallback while faulted", n, 640 / DIV);

    // random clear attempts around the threshold
    for (int k = 0; k < 8; k++) begin
      hmin = 6; hmax = 10;
      edges = ($urandom % 2) ? GOOD + int'($urandom % 4) : GOOD - 1 - int'($urandom % 4);
      restart_after(edges, base);
      do_clear(1, 0);
      chk("R5 random clear", fault, exp_fault_after_clear(edges));
    end

    // R3 stretched period
    restart_after(GOOD + 2, base);
    do_clear(1, 0);
    chk("R5 clear before stretch", fault, 0);
    hmin = 40; hmax = 40;
    cycles(200);
    chk("R3 stretched period faults", fault, 1);

    // R7 bypass
    bypass = 1; route_pin = 1;
    hmin = 10; hmax = 10;
    cycles(3);
    chk("R7 amp off in bypass", amp_on, 0);
    restart_after(GOOD + 2, base);
    do_clear(1, 0);
    chk("R7 pin reference clears fault", fault, 0);
    route_pin = 0;
    cycles(TO + 40);
    chk("R7 crystal input ignored in bypass", fault, 1);
    run = 0;

    chk("R9 no runt high pulses", runts, 0);
    done = 1;
    summary();
  end
endmodule